// File: doc/BRIEF.md
# Flash Command Unlock Sequencer

This block sits on the write side of a parallel NOR-style flash memory and watches every bus write cycle. Each write carries a latched word address and a 16-bit data word. The sequencer looks for multi-cycle instructions, and each instruction must open with a pair of coded unlock writes. It recognises four instructions: return to array reads, electronic-signature reads, word program and whole-chip erase. When a sequence completes, it issues a one-cycle start pulse that carries the decoded operation together with the address and data of the final write.

The block also reports its current mode so that the read path can choose between array data, signature data and operation status. A program or erase keeps the block busy until the array controller reports completion on `op_done`. Until then, all writes are dropped. Any write that does not fit the expected sequence sends the block back to array-read mode without a pulse.

Unlock pattern: low byte 0xAA at word address 0x5555, then low byte 0x55 at 0x2AAA. Command cycles are written at 0x5555. The command codes are 0xA0 (program setup), 0x80 (erase setup), 0x10 (erase confirm), 0x90 (signature) and 0xF0 (reset, accepted at any address).

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, `mode` is 0 (array read) and `start` is low.
- R2: A write that does not match the next expected step of a sequence returns `mode` to 0 and clears any partial sequence, with no start pulse.
- R3: The four writes AA@5555, 55@2AAA, A0@5555, then any data D at any address A produce a pulse with `start_op`=2 (program), `start_addr`=A and `start_data`=D, and `mode` becomes 2 (busy).
- R4: The six writes AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 10@5555 produce a pulse with `start_op`=3 (chip erase), and `mode` becomes 2. Any wrong fourth, fifth or sixth write aborts the erase as in R2.
- R5: The three writes AA@5555, 55@2AAA, 90@5555 produce a pulse with `start_op`=1 and set `mode` to 1 (signature read).
- R6: A write whose low byte is 0xF0, at any address and in any non-busy step, produces a pulse with `start_op`=0 and sets `mode` to 0. This includes writes made from signature mode and writes made part-way through an unlock sequence.
- R7: While `mode` is 2, writes have no effect: no pulse is issued and the mode stays 2.
- R8: A high `op_done` while `mode` is 2 sets `mode` to 0 on the next clock. `op_done` has no effect in any other mode.
- R9: In the program data cycle (the fourth write of R3), a data word whose low byte is 0xF0 is taken as program data and not as a reset.
- R10: Only bits 7:0 of the data word are compared against unlock and command codes. Bits 15:8 are ignored for matching.
- R11: `start` is high for exactly the one clock that follows the write completing an instruction. Writes that only advance or break a sequence never raise it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One bus write cycle this clock |
| wr_addr | input | ADDR_W (16) | Latched word address of the write |
| wr_data | input | DATA_W (16) | Data word of the write |
| op_done | input | 1 | Program or erase has finished |
| start | output | 1 | One-cycle pulse: an instruction was decoded |
| start_op | output | 2 | Decoded operation: 0 read array, 1 signature, 2 program, 3 chip erase |
| start_addr | output | ADDR_W (16) | Address of the completing write |
| start_data | output | DATA_W (16) | Data of the completing write |
| mode | output | 2 | 0 array read, 1 signature read, 2 busy |

## Verification
The bench breaks an erase at its fifth and sixth cycles. A design that only checks the first unlock pair would still start an erase in those cases. It writes 0xF0 as program data, which catches a design that lets the reset code take priority over the data cycle. It writes during busy and pulses `op_done` outside busy, which exposes a busy flag that leaks writes or clears spuriously. It also sets junk in the upper data byte and checks that no pulse appears on intermediate writes, which catches code comparisons that are too wide and pulses that fire early.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_SIG   = 2'd1,
    OP_PROG  = 2'd2,
    OP_ERASE = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    MODE_ARRAY = 2'd0,
    MODE_SIG   = 2'd1,
    MODE_BUSY  = 2'd2
  } mode_e;

  typedef enum logic [2:0] {
    SQ_IDLE = 3'd0,
    SQ_U1   = 3'd1,
    SQ_U2   = 3'd2,
    SQ_PROG = 3'd3,
    SQ_E1   = 3'd4,
    SQ_E2   = 3'd5,
    SQ_E3   = 3'd6
  } seq_e;

  localparam logic [7:0]  KEY_FIRST   = 8'hAA;
  localparam logic [7:0]  KEY_SECOND  = 8'h55;
  localparam logic [7:0]  CMD_PROG    = 8'hA0;
  localparam logic [7:0]  CMD_ERASE   = 8'h80;
  localparam logic [7:0]  CMD_CONFIRM = 8'h10;
  localparam logic [7:0]  CMD_SIG     = 8'h90;
  localparam logic [7:0]  CMD_RESET   = 8'hF0;
  localparam logic [15:0] ADDR_KEY1   = 16'h5555;
  localparam logic [15:0] ADDR_KEY2   = 16'h2AAA;

  // Code match on the command byte only.
  function automatic logic code_is(input logic [7:0] low, input logic [7:0] code);
    return low == code;
  endfunction

endpackage

// File: rtl/flash_cmd_match.sv
module flash_cmd_match
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              hit_key1,
  output logic              hit_key2,
  output logic              hit_prog,
  output logic              hit_erase,
  output logic              hit_confirm,
  output logic              hit_sig,
  output logic              hit_reset
);
  localparam logic [ADDR_W-1:0] A1 = ADDR_W'(ADDR_KEY1);
  localparam logic [ADDR_W-1:0] A2 = ADDR_W'(ADDR_KEY2);

  logic [7:0] low;
  logic       at_a1;
  logic       at_a2;

  assign low   = data[7:0];
  assign at_a1 = (addr == A1);
  assign at_a2 = (addr == A2);

  assign hit_key1    = at_a1 && code_is(low, KEY_FIRST);
  assign hit_key2    = at_a2 && code_is(low, KEY_SECOND);
  assign hit_prog    = at_a1 && code_is(low, CMD_PROG);
  assign hit_erase   = at_a1 && code_is(low, CMD_ERASE);
  assign hit_confirm = at_a1 && code_is(low, CMD_CONFIRM);
  assign hit_sig     = at_a1 && code_is(low, CMD_SIG);
  assign hit_reset   = code_is(low, CMD_RESET);
endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
  import flash_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  logic  op_done,
  input  logic  hit_key1,
  input  logic  hit_key2,
  input  logic  hit_prog,
  input  logic  hit_erase,
  input  logic  hit_confirm,
  input  logic  hit_sig,
  input  logic  hit_reset,
  output mode_e mode_q,
  output seq_e  seq_q,
  output logic  fire,
  output op_e   fire_op,
  output logic  seq_bad
);
  mode_e mode_d;
  seq_e  seq_d;

  always_comb begin
    mode_d  = mode_q;
    seq_d   = seq_q;
    fire    = 1'b0;
    fire_op = OP_READ;
    seq_bad = 1'b0;
    if (mode_q == MODE_BUSY) begin
      if (op_done) mode_d = MODE_ARRAY;
    end else if (wr_en) begin
      if (hit_reset && seq_q != SQ_PROG) begin
        seq_d   = SQ_IDLE;
        mode_d  = MODE_ARRAY;
        fire    = 1'b1;
        fire_op = OP_READ;
      end else begin
        unique case (seq_q)
          SQ_IDLE: if (hit_key1) seq_d = SQ_U1; else seq_bad = 1'b1;
          SQ_U1:   if (hit_key2) seq_d = SQ_U2; else seq_bad = 1'b1;
          SQ_U2: begin
            if (hit_prog)       seq_d = SQ_PROG;
            else if (hit_erase) seq_d = SQ_E1;
            else if (hit_sig) begin
              seq_d   = SQ_IDLE;
              mode_d  = MODE_SIG;
              fire    = 1'b1;
              fire_op = OP_SIG;
            end else seq_bad = 1'b1;
          end
          SQ_PROG: begin
            seq_d   = SQ_IDLE;
            mode_d  = MODE_BUSY;
            fire    = 1'b1;
            fire_op = OP_PROG;
          end
          SQ_E1: if (hit_key1) seq_d = SQ_E2; else seq_bad = 1'b1;
          SQ_E2: if (hit_key2) seq_d = SQ_E3; else seq_bad = 1'b1;
          SQ_E3: begin
            if (hit_confirm) begin
              seq_d   = SQ_IDLE;
              mode_d  = MODE_BUSY;
              fire    = 1'b1;
              fire_op = OP_ERASE;
            end else seq_bad = 1'b1;
          end
          default: seq_bad = 1'b1;
        endcase
        if (seq_bad) begin
          seq_d  = SQ_IDLE;
          mode_d = MODE_ARRAY;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_ARRAY;
      seq_q  <= SQ_IDLE;
    end else begin
      mode_q <= mode_d;
      seq_q  <= seq_d;
    end
  end
endmodule

// File: rtl/flash_start_reg.sv
module flash_start_reg
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  op_e               fire_op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              start_q,
  output op_e               op_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      op_q    <= OP_READ;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      start_q <= fire;
      if (fire) begin
        op_q   <= fire_op;
        addr_q <= addr;
        data_q <= data;
      end
    end
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              op_done,
  output logic              start,
  output logic [1:0]        start_op,
  output logic [ADDR_W-1:0] start_addr,
  output logic [DATA_W-1:0] start_data,
  output logic [1:0]        mode
);
  logic  hit_key1, hit_key2, hit_prog, hit_erase, hit_confirm, hit_sig, hit_reset;
  logic  fire, seq_bad;
  op_e   fire_op, op_q;
  mode_e mode_q;
  seq_e  seq_q;

  flash_cmd_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
    .addr(wr_addr), .data(wr_data),
    .hit_key1(hit_key1), .hit_key2(hit_key2), .hit_prog(hit_prog),
    .hit_erase(hit_erase), .hit_confirm(hit_confirm), .hit_sig(hit_sig),
    .hit_reset(hit_reset)
  );

  flash_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .op_done(op_done),
    .hit_key1(hit_key1), .hit_key2(hit_key2), .hit_prog(hit_prog),
    .hit_erase(hit_erase), .hit_confirm(hit_confirm), .hit_sig(hit_sig),
    .hit_reset(hit_reset),
    .mode_q(mode_q), .seq_q(seq_q), .fire(fire), .fire_op(fire_op),
    .seq_bad(seq_bad)
  );

  flash_start_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_start (
    .clk(clk), .rst_n(rst_n), .fire(fire), .fire_op(fire_op),
    .addr(wr_addr), .data(wr_data),
    .start_q(start), .op_q(op_q), .addr_q(start_addr), .data_q(start_data)
  );

  assign start_op = op_q;
  assign mode     = mode_q;
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       op_done,
  input logic       start,
  input logic [1:0] start_op,
  input logic [1:0] mode,
  input logic       seq_bad
);
  p_bad_to_array_r2: assert property (@(posedge clk) disable iff (!rst_n)
    seq_bad |=> (mode == 2'd0 && !start));

  p_prog_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && start_op == 2'd2) |-> mode == 2'd2);

  p_erase_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && start_op == 2'd3) |-> mode == 2'd2);

  p_sig_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && start_op == 2'd1) |-> mode == 2'd1);

  p_read_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && start_op == 2'd0) |-> mode == 2'd0);

  p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && !op_done) |=> (mode == 2'd2 && !start));

  p_busy_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && op_done) |=> mode == 2'd0);

  p_start_after_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> $past(wr_en));
endmodule

bind flash_cmd_seq flash_cmd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .op_done(op_done),
  .start(start), .start_op(start_op), .mode(mode), .seq_bad(seq_bad)
);

// File: tb/flash_cmd_seq_test.sv
module flash_cmd_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        op_done = 1'b0;
  logic        start;
  logic [1:0]  start_op;
  logic [15:0] start_addr;
  logic [15:0] start_data;
  logic [1:0]  mode;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  flash_cmd_seq uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .op_done(op_done), .start(start), .start_op(start_op),
    .start_addr(start_addr), .start_data(start_data), .mode(mode)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One write; returns at the next falling edge with outputs settled.
  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic unlock(input string req);
    wr(16'h5555, 16'h00AA); chk({req, " no pulse on unlock1"}, start, 0);
    wr(16'h2AAA, 16'h0055); chk({req, " no pulse on unlock2"}, start, 0);
  endtask

  task automatic finish_op(input string req);
    op_done = 1'b1; @(negedge clk); op_done = 1'b0;
    chk({req, " released"}, mode, 0);
  endtask

  task automatic t_reset;
    chk("R1 mode", mode, 0);
    chk("R1 start", start, 0);
  endtask

  task automatic t_program;
    unlock("R11");
    wr(16'h5555, 16'h00A0); chk("R11 setup no pulse", start, 0);
    wr(16'h0ABC, 16'h1234);
    chk("R3 start", start, 1);
    chk("R3 op", start_op, 2);
    chk("R3 addr", start_addr, 16'h0ABC);
    chk("R3 data", start_data, 16'h1234);
    chk("R3 busy", mode, 2);
    @(negedge clk);
    chk("R11 single cycle", start, 0);
  endtask

  task automatic t_busy_ignore;
    wr(16'h1111, 16'h00F0);
    chk("R7 no pulse", start, 0);
    chk("R7 still busy", mode, 2);
    wr(16'h5555, 16'h00AA);
    chk("R7 still busy 2", mode, 2);
    finish_op("R8");
    // A sequence started during busy must not be continued afterwards.
    wr(16'h2AAA, 16'h0055);
    wr(16'h5555, 16'h0090);
    chk("R7 busy writes dropped", start, 0);
    chk("R7 mode array", mode, 0);
  endtask

  task automatic t_erase;
    unlock("R4");
    wr(16'h5555, 16'h0080); chk("R11 erase setup no pulse", start, 0);
    unlock("R4");
    wr(16'h5555, 16'h0010);
    chk("R4 start", start, 1);
    chk("R4 op", start_op, 3);
    chk("R4 busy", mode, 2);
    finish_op("R8 erase");
  endtask

  task automatic t_erase_broken;
    unlock("R4");
    wr(16'h5555, 16'h0080);
    wr(16'h5555, 16'h00AA);
    wr(16'h2AAB, 16'h0055);
    wr(16'h5555, 16'h0010);
    chk("R4 bad 5th no start", start, 0);
    chk("R4 bad 5th mode", mode, 0);
    unlock("R4");
    wr(16'h5555, 16'h0080);
    unlock("R4");
    wr(16'h5555, 16'h0030);
    chk("R2 bad confirm no start", start, 0);
    chk("R2 bad confirm mode", mode, 0);
  endtask

  task automatic t_signature;
    unlock("R5");
    wr(16'h5555, 16'h0090);
    chk("R5 start", start, 1);
    chk("R5 op", start_op, 1);
    chk("R5 mode", mode, 1);
    op_done = 1'b1; @(negedge clk); op_done = 1'b0;
    chk("R8 op_done ignored", mode, 1);
    wr(16'h7777, 16'h00F0);
    chk("R6 start", start, 1);
    chk("R6 op", start_op, 0);
    chk("R6 mode", mode, 0);
  endtask

  task automatic t_bad_unlock;
    wr(16'h1555, 16'h00AA);
    wr(16'h2AAA, 16'h0055);
    wr(16'h5555, 16'h0090);
    chk("R2 wrong addr no start", start, 0);
    chk("R2 wrong addr mode", mode, 0);
    unlock("R2");
    wr(16'h5555, 16'h0090);
    wr(16'h0000, 16'h0012);
    chk("R2 sig exit mode", mode, 0);
    chk("R2 sig exit no start", start, 0);
  endtask

  task automatic t_reset_midseq;
    wr(16'h5555, 16'h00AA);
    wr(16'h3000, 16'hABF0);
    chk("R6 mid start", start, 1);
    chk("R6 mid op", start_op, 0);
    wr(16'h2AAA, 16'h0055);
    wr(16'h5555, 16'h0090);
    chk("R6 seq cleared", mode, 0);
  endtask

  task automatic t_prog_f0;
    unlock("R9");
    wr(16'h5555, 16'h00A0);
    wr(16'h0042, 16'h00F0);
    chk("R9 start", start, 1);
    chk("R9 op", start_op, 2);
    chk("R9 data", start_data, 16'h00F0);
    chk("R9 busy", mode, 2);
    finish_op("R9");
  endtask

  task automatic t_upper_byte;
    wr(16'h5555, 16'hFFAA);
    wr(16'h2AAA, 16'h3C55);
    wr(16'h5555, 16'h8190);
    chk("R10 start", start, 1);
    chk("R10 op", start_op, 1);
    chk("R10 mode", mode, 1);
    wr(16'h0000, 16'h00F0);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_program;
    t_busy_ignore;
    t_erase;
    t_erase_broken;
    t_signature;
    t_bad_unlock;
    t_reset_midseq;
    t_prog_f0;
    t_upper_byte;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule